// File: doc/BRIEF.md
# Dispatched Op Sampling Tagger

This block samples micro-ops for profiling. It watches the dispatch stream, picks one op, and follows that op until it retires or is flushed. Two programmable selection bases are offered. In cycle mode a counter advances once per clock, and when the counter reaches its limit the block takes the dispatch group present in that cycle. A small pseudo-random index then selects one valid op inside that group. In op mode the counter advances once per dispatched op, and the op whose dispatch brings the counter to its limit is the one tagged.

While an op is tagged, the block timestamps the first completion event for that op and records the first data-cache-miss report for it. When the op retires, the block freezes a sample and pulses an interrupt. The sample holds the retire flags, the tag-to-retire and completion-to-retire cycle counts, and the miss latency with 64-bit virtual and physical miss addresses. A flushed op leaves no trace. Software may load the current count at any time, which lets it randomize the sampling period. It releases a held sample by pulsing a clear.

Top module: `op_sample_tagger`

## Requirements
- R1: After reset no op is tagged, no sample is held and the interrupt is low.
- R2: In op mode (`cfg_op_mode`=1), every valid op of a dispatch group advances the count by one, taking slots in the order 0, 1, 2 (slot i uses `disp_tag` bits [i*TAG_W +: TAG_W]). The op whose increment makes the count reach `cfg_max` is tagged in the next cycle, and at most one op is tagged per group.
- R3: In cycle mode (`cfg_op_mode`=0), the count rises by one per cycle. A group presented while the count is below `cfg_max` is not tagged. A group with at least one valid op presented in the cycle where the count has reached `cfg_max` has exactly one of its valid ops tagged. That op is the one at rank (state mod valid-op count) among the valid slots, where the state comes from a free-running 3-bit LFSR seeded to 1 with next value {s[1:0], s[2]^s[1]}.
- R4: In cycle mode, if no valid op is presented in the cycle where the count has reached `cfg_max`, no op is tagged and the count restarts from zero.
- R5: A `cnt_load` pulse writes `cnt_load_val` into the count for the next cycle, taking priority over every other count update.
- R6: While an op is tracked or a sample is held, no new op is tagged. Completion, miss, retire and flush events carrying any other tag are ignored.
- R7: A retire event for the tagged op sets `smp_valid` and pulses `smp_irq` for one cycle in that same cycle. The sample holds until `smp_clear`, after which counting resumes from zero.
- R8: `smp_tag2ret` equals the number of cycles from the dispatch cycle of the tagged op to its retire cycle. `smp_cmp2ret` equals the cycles from its first completion event to retire, or 0 if no completion was seen. Both saturate.
- R9: The first miss report for the tagged op sets `smp_dc_miss` and captures its latency and both addresses. Without a miss report these three fields read zero and `smp_dc_miss` is clear.
- R10: A flush of the tagged op ends tracking without a sample or interrupt and restarts counting from zero. A later retire of that tag has no effect.
- R11: `smp_flags` holds the `ret_flags` value presented with the tagged op's retire event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_op_mode | input | 1 | 1 counts dispatched ops, 0 counts cycles |
| cfg_max | input | 20 | Count limit that triggers selection |
| cnt_load | input | 1 | Load pulse for the current count |
| cnt_load_val | input | 20 | Value written by `cnt_load` |
| disp_valid | input | 3 | Per-slot valid mask of the dispatch group |
| disp_tag | input | 18 | Op tags of the dispatch group, slot 0 in the low bits |
| cmpl_valid | input | 1 | Completion event strobe |
| cmpl_tag | input | 6 | Tag of the completing op |
| ret_valid | input | 1 | Retire event strobe |
| ret_tag | input | 6 | Tag of the retiring op |
| ret_flags | input | 4 | Event flags reported at retire |
| flush_valid | input | 1 | Flush event strobe |
| flush_tag | input | 6 | Tag of the flushed op |
| dcm_valid | input | 1 | Data-cache-miss report strobe |
| dcm_tag | input | 6 | Tag of the op that missed |
| dcm_lat | input | 12 | Miss latency in cycles |
| dcm_vaddr | input | 64 | Virtual miss address |
| dcm_paddr | input | 64 | Physical miss address |
| smp_clear | input | 1 | Software release of a held sample |
| trk_busy | output | 1 | An op is being tracked |
| trk_tag | output | 6 | Tag of the tracked op |
| smp_valid | output | 1 | A sample is held |
| smp_irq | output | 1 | One-cycle interrupt when a sample is captured |
| smp_flags | output | 4 | Captured retire flags |
| smp_dc_miss | output | 1 | The sampled op reported a miss |
| smp_tag2ret | output | 12 | Tag-to-retire cycles |
| smp_cmp2ret | output | 12 | Completion-to-retire cycles |
| smp_miss_lat | output | 12 | Captured miss latency |
| smp_vaddr | output | 64 | Captured virtual miss address |
| smp_paddr | output | 64 | Captured physical miss address |

## Verification
The hardest case to reach from the ports is the cycle-mode decision cycle. Whether a group is tagged, skipped or ignored depends on the count having reached the limit in exactly that cycle. The stimulus therefore loads the count to zero and then places groups one cycle early, exactly on the decision cycle, or not at all. This makes tagging, a skip and the restart after a skip each visible on `trk_busy`. In op mode, loaded counts put the threshold in the middle of a partly valid group, which shows that only the crossing slot is tagged.

// File: rtl/tagger_pkg.sv
package tagger_pkg;
    typedef enum logic [1:0] {
        PH_COUNT = 2'd0,
        PH_TRACK = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;
endpackage

// File: rtl/tagger_lfsr.sv
module tagger_lfsr #(
    parameter int RND_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd_o
);
    logic [RND_W-1:0] lfsr_d, lfsr_q;

    // taps for x^3 + x^2 + 1
    always_comb begin
        lfsr_d = {lfsr_q[RND_W-2:0], lfsr_q[RND_W-1] ^ lfsr_q[RND_W-2]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= RND_W'(1);
        else        lfsr_q <= lfsr_d;
    end

    assign rnd_o = lfsr_q;
endmodule

// File: rtl/tagger_select.sv
module tagger_select #(
    parameter int CNT_W = 20,
    parameter int TAG_W = 6,
    parameter int SLOTS = 3,
    parameter int RND_W = 3
) (
    input  logic                   op_mode_i,
    input  logic [CNT_W-1:0]       count_i,
    input  logic [CNT_W-1:0]       max_i,
    input  logic [SLOTS-1:0]       valid_i,
    input  logic [SLOTS*TAG_W-1:0] tags_i,
    input  logic [RND_W-1:0]       rnd_i,
    output logic                   hit_o,
    output logic [TAG_W-1:0]       tag_o,
    output logic [CNT_W-1:0]       count_o
);
    localparam int IDX_W = $clog2(SLOTS + 1);
    localparam int SUM_W = CNT_W + IDX_W;

    logic [SUM_W-1:0] run;
    logic [IDX_W-1:0] nvalid, pick, rank;
    logic             expired;

    always_comb begin
        hit_o   = 1'b0;
        tag_o   = '0;
        count_o = count_i;
        run     = SUM_W'(count_i);
        pick    = '0;
        rank    = '0;
        nvalid  = '0;
        expired = (count_i >= max_i);
        for (int i = 0; i < SLOTS; i++) nvalid = nvalid + IDX_W'(valid_i[i]);
        if (op_mode_i) begin
            // ops counted in slot order; the crossing op wins
            for (int i = 0; i < SLOTS; i++) begin
                if (valid_i[i] && !hit_o) begin
                    run = run + SUM_W'(1);
                    if (run >= SUM_W'(max_i)) begin
                        hit_o = 1'b1;
                        tag_o = tags_i[i*TAG_W +: TAG_W];
                    end
                end
            end
            count_o = hit_o ? '0 : CNT_W'(run);
        end else begin
            if (nvalid != '0) pick = IDX_W'(int'(rnd_i) % int'(nvalid));
            for (int i = 0; i < SLOTS; i++) begin
                if (valid_i[i]) begin
                    if (expired && rank == pick) begin
                        hit_o = 1'b1;
                        tag_o = tags_i[i*TAG_W +: TAG_W];
                    end
                    rank = rank + IDX_W'(1);
                end
            end
            count_o = expired ? '0 : count_i + CNT_W'(1);
        end
    end
endmodule

// File: rtl/op_sample_tagger.sv
module op_sample_tagger
    import tagger_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int TAG_W  = 6,
    parameter int LAT_W  = 12,
    parameter int FLAG_W = 4,
    parameter int ADDR_W = 64,
    parameter int SLOTS  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_op_mode,
    input  logic [CNT_W-1:0]       cfg_max,
    input  logic                   cnt_load,
    input  logic [CNT_W-1:0]       cnt_load_val,
    input  logic [SLOTS-1:0]       disp_valid,
    input  logic [SLOTS*TAG_W-1:0] disp_tag,
    input  logic                   cmpl_valid,
    input  logic [TAG_W-1:0]       cmpl_tag,
    input  logic                   ret_valid,
    input  logic [TAG_W-1:0]       ret_tag,
    input  logic [FLAG_W-1:0]      ret_flags,
    input  logic                   flush_valid,
    input  logic [TAG_W-1:0]       flush_tag,
    input  logic                   dcm_valid,
    input  logic [TAG_W-1:0]       dcm_tag,
    input  logic [LAT_W-1:0]       dcm_lat,
    input  logic [ADDR_W-1:0]      dcm_vaddr,
    input  logic [ADDR_W-1:0]      dcm_paddr,
    input  logic                   smp_clear,
    output logic                   trk_busy,
    output logic [TAG_W-1:0]       trk_tag,
    output logic                   smp_valid,
    output logic                   smp_irq,
    output logic [FLAG_W-1:0]      smp_flags,
    output logic                   smp_dc_miss,
    output logic [LAT_W-1:0]       smp_tag2ret,
    output logic [LAT_W-1:0]       smp_cmp2ret,
    output logic [LAT_W-1:0]       smp_miss_lat,
    output logic [ADDR_W-1:0]      smp_vaddr,
    output logic [ADDR_W-1:0]      smp_paddr
);
    localparam int RND_W = 3;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  count;
        logic [TAG_W-1:0]  tag;
        logic              cmpl_seen;
        logic [LAT_W-1:0]  t2r;
        logic [LAT_W-1:0]  c2r;
        logic              irq;
        logic [FLAG_W-1:0] flags;
        logic              miss;
        logic [LAT_W-1:0]  lat;
        logic [ADDR_W-1:0] va;
        logic [ADDR_W-1:0] pa;
    } state_t;

    state_t s_d, s_q;

    logic [RND_W-1:0] rnd;
    logic             pick_hit;
    logic [TAG_W-1:0] pick_tag;
    logic [CNT_W-1:0] pick_count;

    tagger_lfsr #(.RND_W(RND_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    tagger_select #(
        .CNT_W (CNT_W),
        .TAG_W (TAG_W),
        .SLOTS (SLOTS),
        .RND_W (RND_W)
    ) u_select (
        .op_mode_i (cfg_op_mode),
        .count_i   (s_q.count),
        .max_i     (cfg_max),
        .valid_i   (disp_valid),
        .tags_i    (disp_tag),
        .rnd_i     (rnd),
        .hit_o     (pick_hit),
        .tag_o     (pick_tag),
        .count_o   (pick_count)
    );

    logic cmpl_hit, ret_hit, flush_hit, dcm_hit;
    assign cmpl_hit  = cmpl_valid  && (cmpl_tag  == s_q.tag);
    assign ret_hit   = ret_valid   && (ret_tag   == s_q.tag);
    assign flush_hit = flush_valid && (flush_tag == s_q.tag);
    assign dcm_hit   = dcm_valid   && (dcm_tag   == s_q.tag);

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        unique case (s_q.phase)
            PH_COUNT: begin
                if (pick_hit) begin
                    s_d.phase     = PH_TRACK;
                    s_d.tag       = pick_tag;
                    s_d.count     = '0;
                    s_d.cmpl_seen = 1'b0;
                    s_d.t2r       = '0;
                    s_d.c2r       = '0;
                    s_d.flags     = '0;
                    s_d.miss      = 1'b0;
                    s_d.lat       = '0;
                    s_d.va        = '0;
                    s_d.pa        = '0;
                end else begin
                    s_d.count = pick_count;
                end
            end
            PH_TRACK: begin
                if (!(&s_q.t2r)) s_d.t2r = s_q.t2r + LAT_W'(1);
                if (s_q.cmpl_seen && !(&s_q.c2r)) s_d.c2r = s_q.c2r + LAT_W'(1);
                if (cmpl_hit && !s_q.cmpl_seen) s_d.cmpl_seen = 1'b1;
                if (dcm_hit && !s_q.miss) begin
                    s_d.miss = 1'b1;
                    s_d.lat  = dcm_lat;
                    s_d.va   = dcm_vaddr;
                    s_d.pa   = dcm_paddr;
                end
                if (flush_hit) begin
                    s_d.phase = PH_COUNT;
                    s_d.count = '0;
                end else if (ret_hit) begin
                    s_d.phase = PH_HOLD;
                    s_d.irq   = 1'b1;
                    s_d.flags = ret_flags;
                end
            end
            PH_HOLD: begin
                if (smp_clear) begin
                    s_d.phase = PH_COUNT;
                    s_d.count = '0;
                end
            end
            default: s_d.phase = PH_COUNT;
        endcase
        if (cnt_load) s_d.count = cnt_load_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trk_busy     = (s_q.phase == PH_TRACK);
    assign trk_tag      = s_q.tag;
    assign smp_valid    = (s_q.phase == PH_HOLD);
    assign smp_irq      = s_q.irq;
    assign smp_flags    = s_q.flags;
    assign smp_dc_miss  = s_q.miss;
    assign smp_tag2ret  = s_q.t2r;
    assign smp_cmp2ret  = s_q.c2r;
    assign smp_miss_lat = s_q.lat;
    assign smp_vaddr    = s_q.va;
    assign smp_paddr    = s_q.pa;
endmodule

// File: rtl/op_sample_tagger_chk.sv
module op_sample_tagger_chk #(
    parameter int TAG_W  = 6,
    parameter int LAT_W  = 12,
    parameter int ADDR_W = 64,
    parameter int SLOTS  = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [SLOTS-1:0]       disp_valid,
    input logic [SLOTS*TAG_W-1:0] disp_tag,
    input logic                   flush_valid,
    input logic [TAG_W-1:0]       flush_tag,
    input logic                   smp_clear,
    input logic                   trk_busy,
    input logic [TAG_W-1:0]       trk_tag,
    input logic                   smp_valid,
    input logic                   smp_irq,
    input logic                   smp_dc_miss,
    input logic [LAT_W-1:0]       smp_tag2ret,
    input logic [LAT_W-1:0]       smp_miss_lat,
    input logic [ADDR_W-1:0]      smp_vaddr,
    input logic [ADDR_W-1:0]      smp_paddr
);
    logic [SLOTS-1:0]       prev_valid_q;
    logic [SLOTS*TAG_W-1:0] prev_tag_q;
    logic                   in_group;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid_q <= '0;
            prev_tag_q   <= '0;
        end else begin
            prev_valid_q <= disp_valid;
            prev_tag_q   <= disp_tag;
        end
    end

    always_comb begin
        in_group = 1'b0;
        for (int i = 0; i < SLOTS; i++)
            if (prev_valid_q[i] && prev_tag_q[i*TAG_W +: TAG_W] == trk_tag) in_group = 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !trk_busy && !smp_valid && !smp_irq); // R1
    AST_TAG_FROM_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trk_busy) |-> in_group); // R3
    AST_SINGLE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(trk_busy && smp_valid)); // R6
    AST_IRQ_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_irq |-> smp_valid && !$past(smp_valid)); // R7
    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !smp_clear |=> smp_valid && $stable(smp_vaddr) && $stable(smp_tag2ret)); // R7
    AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && smp_clear |=> !smp_valid); // R7
    AST_NO_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !smp_dc_miss |-> smp_miss_lat == '0 && smp_vaddr == '0 && smp_paddr == '0); // R9
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        trk_busy && flush_valid && flush_tag == trk_tag |=> !trk_busy && !smp_valid && !smp_irq); // R10
endmodule

bind op_sample_tagger op_sample_tagger_chk #(
    .TAG_W  (TAG_W),
    .LAT_W  (LAT_W),
    .ADDR_W (ADDR_W),
    .SLOTS  (SLOTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid   (disp_valid),
    .disp_tag     (disp_tag),
    .flush_valid  (flush_valid),
    .flush_tag    (flush_tag),
    .smp_clear    (smp_clear),
    .trk_busy     (trk_busy),
    .trk_tag      (trk_tag),
    .smp_valid    (smp_valid),
    .smp_irq      (smp_irq),
    .smp_dc_miss  (smp_dc_miss),
    .smp_tag2ret  (smp_tag2ret),
    .smp_miss_lat (smp_miss_lat),
    .smp_vaddr    (smp_vaddr),
    .smp_paddr    (smp_paddr)
);

// File: tb/op_sample_tagger_test.sv
module op_sample_tagger_test;
    localparam int CNT_W = 20, TAG_W = 6, LAT_W = 12, FLAG_W = 4, ADDR_W = 64, SLOTS = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                   rst_n, cfg_op_mode, cnt_load;
    logic [CNT_W-1:0]       cfg_max, cnt_load_val;
    logic [SLOTS-1:0]       disp_valid;
    logic [SLOTS*TAG_W-1:0] disp_tag;
    logic                   cmpl_valid, ret_valid, flush_valid, dcm_valid, smp_clear;
    logic [TAG_W-1:0]       cmpl_tag, ret_tag, flush_tag, dcm_tag;
    logic [FLAG_W-1:0]      ret_flags;
    logic [LAT_W-1:0]       dcm_lat;
    logic [ADDR_W-1:0]      dcm_vaddr, dcm_paddr;
    logic                   trk_busy, smp_valid, smp_irq, smp_dc_miss;
    logic [TAG_W-1:0]       trk_tag;
    logic [FLAG_W-1:0]      smp_flags;
    logic [LAT_W-1:0]       smp_tag2ret, smp_cmp2ret, smp_miss_lat;
    logic [ADDR_W-1:0]      smp_vaddr, smp_paddr;

    op_sample_tagger uut (.*);

    typedef struct {
        logic [FLAG_W-1:0] flags;
        logic              miss;
        logic [LAT_W-1:0]  t2r, c2r, lat;
        logic [ADDR_W-1:0] va, pa;
    } smp_t;

    smp_t expq[$];
    int n_chk = 0, n_bad = 0;

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        cnt_load = 0; disp_valid = '0; disp_tag = '0;
        cmpl_valid = 0; ret_valid = 0; flush_valid = 0; dcm_valid = 0; smp_clear = 0;
    endtask

    task automatic group(input logic [2:0] v, input logic [5:0] t0, t1, t2);
        disp_valid = v; disp_tag = {t2, t1, t0};
    endtask

    task automatic load(input int val);
        cnt_load = 1; cnt_load_val = CNT_W'(val);
        tick(); quiet();
    endtask

    // monitor: pop the expected sample at each interrupt
    always @(negedge clk) begin : monitor
        smp_t e;
        if (rst_n && smp_irq) begin
            if (expq.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R10 unexpected interrupt: actual 1 expected 0");
            end else begin
                e = expq.pop_front();
                check("R11", "flags", 64'(smp_flags), 64'(e.flags));
                check("R8", "tag2ret", 64'(smp_tag2ret), 64'(e.t2r));
                check("R8", "cmp2ret", 64'(smp_cmp2ret), 64'(e.c2r));
                check("R9", "miss", 64'(smp_dc_miss), 64'(e.miss));
                check("R9", "lat", 64'(smp_miss_lat), 64'(e.lat));
                check("R9", "vaddr", smp_vaddr, e.va);
                check("R9", "paddr", smp_paddr, e.pa);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; cfg_op_mode = 1; cfg_max = 4; cnt_load_val = '0;
        cmpl_tag = '0; ret_tag = '0; flush_tag = '0; dcm_tag = '0; ret_flags = '0;
        dcm_lat = '0; dcm_vaddr = '0; dcm_paddr = '0;
        quiet();
        repeat (3) tick();
        check("R1", "busy", 64'(trk_busy), 0);
        check("R1", "valid", 64'(smp_valid), 0);
        check("R1", "irq", 64'(smp_irq), 0);
        rst_n = 1;

        // R2: op mode, threshold falls on slot 1 of the second group
        load(0);
        group(3'b011, 1, 2, 0); tick(); quiet();
        check("R2", "no tag below max", 64'(trk_busy), 0);
        group(3'b111, 3, 4, 5); tick(); quiet();
        check("R2", "busy", 64'(trk_busy), 1);
        check("R2", "crossing op", 64'(trk_tag), 4);
        // cycle 1: completion, foreign retire and miss, new group
        cmpl_valid = 1; cmpl_tag = 4; ret_valid = 1; ret_tag = 9;
        dcm_valid = 1; dcm_tag = 5; dcm_lat = 99; dcm_vaddr = 64'hdead; dcm_paddr = 64'hbeef;
        group(3'b111, 6, 7, 8); tick(); quiet();
        check("R6", "still tracking", 64'(trk_busy), 1);
        check("R6", "same tag", 64'(trk_tag), 4);
        check("R6", "no sample", 64'(smp_valid), 0);
        // cycle 2: own miss report
        dcm_valid = 1; dcm_tag = 4; dcm_lat = 37;
        dcm_vaddr = 64'h1234_5678_9abc_def0; dcm_paddr = 64'h0fed_cba9_8765_4321;
        tick(); quiet();
        dcm_valid = 1; dcm_tag = 4; dcm_lat = 55; dcm_vaddr = 64'h1; dcm_paddr = 64'h2; // later miss ignored
        tick(); quiet();
        flush_valid = 1; flush_tag = 7; tick(); quiet();
        check("R6", "foreign flush ignored", 64'(trk_busy), 1);
        expq.push_back('{flags: 4'b1010, miss: 1'b1, t2r: 12'd5, c2r: 12'd4, lat: 12'd37,
                         va: 64'h1234_5678_9abc_def0, pa: 64'h0fed_cba9_8765_4321});
        ret_valid = 1; ret_tag = 4; ret_flags = 4'b1010; tick(); quiet();
        check("R7", "sample valid", 64'(smp_valid), 1);
        check("R7", "busy off", 64'(trk_busy), 0);
        group(3'b111, 10, 11, 12); tick();
        group(3'b111, 13, 14, 15); tick(); quiet();
        check("R6", "no tag while held", 64'(trk_busy), 0);
        check("R7", "sample held", 64'(smp_valid), 1);
        check("R7", "irq one cycle", 64'(smp_irq), 0);
        smp_clear = 1; tick(); quiet();
        check("R7", "cleared", 64'(smp_valid), 0);

        // R7/R10: counting restarts from zero, then flush
        group(3'b111, 40, 41, 42); tick();
        group(3'b011, 43, 44, 0); tick(); quiet();
        check("R7", "restart count tags 4th op", 64'(trk_tag), 43);
        check("R7", "busy after restart", 64'(trk_busy), 1);
        flush_valid = 1; flush_tag = 43; ret_valid = 1; ret_tag = 43; tick(); quiet();
        check("R10", "flush ends tracking", 64'(trk_busy), 0);
        check("R10", "no sample", 64'(smp_valid), 0);
        check("R10", "no irq", 64'(smp_irq), 0);
        ret_valid = 1; ret_tag = 43; tick(); quiet();
        check("R10", "late retire ignored", 64'(smp_valid), 0);

        // R5: loaded count, threshold on slot 1 with slot 0 empty
        load(3);
        group(3'b110, 0, 11, 12); tick(); quiet();
        check("R5", "loaded count tag", 64'(trk_tag), 11);
        check("R5", "busy", 64'(trk_busy), 1);
        tick();
        expq.push_back('{flags: 4'b0001, miss: 1'b0, t2r: 12'd2, c2r: 12'd0, lat: 12'd0, va: 64'd0, pa: 64'd0});
        ret_valid = 1; ret_tag = 11; ret_flags = 4'b0001; tick(); quiet();
        check("R9", "no miss sample", 64'(smp_valid), 1);
        smp_clear = 1; tick(); quiet();

        // R3: cycle mode
        cfg_op_mode = 0; cfg_max = 3;
        load(0);
        tick();                                     // count 0
        group(3'b001, 20, 0, 0); tick(); quiet();   // count 1
        check("R3", "early group not tagged", 64'(trk_busy), 0);
        tick();                                     // count 2
        group(3'b100, 0, 0, 21); tick(); quiet();   // count 3
        check("R3", "group on limit tagged", 64'(trk_busy), 1);
        check("R3", "single op chosen", 64'(trk_tag), 21);
        flush_valid = 1; flush_tag = 21; tick(); quiet();

        // R4: skip when no group at the limit
        cfg_max = 2;
        load(0);
        tick(); tick(); tick();                     // counts 0,1,2: skip
        check("R4", "skip no tag", 64'(trk_busy), 0);
        group(3'b001, 22, 0, 0); tick(); quiet();   // count 0 again
        check("R4", "restart after skip", 64'(trk_busy), 0);
        tick();                                     // count 1
        group(3'b010, 0, 23, 0); tick(); quiet();   // count 2
        check("R4", "tag after recount", 64'(trk_busy), 1);
        check("R4", "tag value", 64'(trk_tag), 23);
        flush_valid = 1; flush_tag = 23; tick(); quiet();

        // R3: full group, one of three chosen
        cfg_max = 1;
        load(0);
        tick();
        group(3'b111, 30, 31, 32); tick(); quiet();
        check("R3", "full group tagged", 64'(trk_busy), 1);
        check("R3", "tag in group", 64'(trk_tag >= 30 && trk_tag <= 32), 1);
        expq.push_back('{flags: 4'b0100, miss: 1'b0, t2r: 12'd1, c2r: 12'd0, lat: 12'd0, va: 64'd0, pa: 64'd0});
        ret_valid = 1; ret_tag = trk_tag; ret_flags = 4'b0100; tick(); quiet();
        check("R7", "cycle mode sample", 64'(smp_valid), 1);
        smp_clear = 1; tick(); quiet();
        tick();
        check("R7", "all samples seen", 64'(expq.size()), 0);
        finish_run();
    end
endmodule